// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec with Error Counters

This block pairs a registered Hamming encoder with a registered Hamming decoder. The encoder takes a message word whose width is a build-time parameter. It returns the same word together with the check bits for it. The decoder receives a message word and check bits that may have been corrupted in transit. It recomputes the syndrome and either repairs a single flipped bit or only reports the fault. Two saturating counters record how many words were repaired and how many were flagged without repair.

Build-time options choose the code. The options are:
- a plain Hamming code, which corrects one error;
- a Hamming code with an additional overall parity bit, which also detects two errors;
- a degenerate code with a single even-parity bit, which only detects errors.

Correction can be switched off separately. In that case every fault is only counted and the received word passes through unchanged. The check-bit positions are derived from the message width when the design is elaborated.

The encoder side and the decoder side each have their own enable. Both sides share a rising-edge clock and an asynchronous, active-high reset. In normal use the encoder outputs are routed to the decoder inputs over the path to be protected.

Top module: `hc_codec_top`

## Requirements
- R1: With no corrupted bits, `dec_out` equals the `enc_msg` value applied two rising edges earlier, when both enables are high and `enc_data`/`enc_par` are routed unchanged to `dec_data`/`dec_par`. Neither counter changes.
- R2: The Hamming check-bit count r is the smallest value with 2^r >= MSG_W + r + 1. Message bit k sits at the k-th codeword position (counting from 1) that is not a power of two. Check bit i (`enc_par[i]`, i < r) is the XOR of the message bits whose position has bit i set. With the overall option, `enc_par[r]` is the XOR of all message bits and all r check bits. In single-parity mode `enc_par` is one bit equal to the XOR of the message. For MSG_W = 8, r = 4, and `enc_par` is 5 bits wide with the overall option.
- R3: With the overall option and correction on, a word with exactly one flipped message bit is restored on `dec_out`, and `fix_cnt` increases by one.
- R4: With the overall option, a word with exactly two flipped message bits is passed through unmodified, and `det_cnt` increases by one. `fix_cnt` does not change.
- R5: With correction off, any detected fault passes the received word through unmodified, increments `det_cnt` and never increments `fix_cnt`.
- R6: In single-parity mode, an odd number of flipped message bits passes through unmodified and increments `det_cnt`. An even number goes unnoticed. `fix_cnt` stays at zero.
- R7: Each counter increases by at most one per cycle and holds at all ones instead of wrapping.
- R8: A one-cycle high pulse on `cnt_clr` makes both counters zero after the next rising edge. The clear wins over an increment in the same cycle.
- R9: While `enc_en` is low the encoder outputs hold. While `dec_en` is low, `dec_out` and both counters hold, whatever the inputs carry.
- R10: Raising `rst` immediately forces all registered outputs and both counters to zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| enc_en | input | 1 | Encoder register enable |
| enc_msg | input | MSG_W | Message word to encode |
| enc_data | output | MSG_W | Registered message word |
| enc_par | output | PAR_W | Registered check bits |
| dec_en | input | 1 | Decoder register and counter enable |
| dec_data | input | MSG_W | Received message word |
| dec_par | input | PAR_W | Received check bits |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| dec_out | output | MSG_W | Registered repaired or forwarded word |
| fix_cnt | output | CNT_W | Saturating count of repaired words |
| det_cnt | output | CNT_W | Saturating count of flagged, unrepaired words |

## Verification
The hardest situation to reach from the ports is a clear pulse that lands in the very cycle a corrupted word reaches the decoder. The clear must win over the increment, and this is only visible if the two line up on the same edge. The stimulus first drives the counters into saturation with a run of single-bit faults, which also covers the hold-at-all-ones case. It then places a faulty word in the encoder and raises the clear exactly one cycle later. The bench runs three codec variants side by side on the same stimulus and the same injected faults, so one stimulus shows the different responses of the variants: repair, flag only, and miss of an even fault.

// File: rtl/hc_pkg.sv
`timescale 1ns/1ps
package hc_pkg;

    // Smallest r with 2^r >= m + r + 1.
    function automatic int hc_ham_bits(int msg_w);
        int r;
        r = 1;
        while ((1 << r) < msg_w + r + 1) r++;
        return r;
    endfunction

    function automatic bit hc_is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Codeword position (from 1) of message bit k: k-th non-power-of-two index.
    function automatic int hc_data_pos(int k);
        int seen;
        seen = 0;
        for (int p = 3; p < 65536; p++) begin
            if (!hc_is_pow2(p)) begin
                if (seen == k) return p;
                seen++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/hc_enc.sv
`timescale 1ns/1ps
module hc_enc
    import hc_pkg::*;
#(
    parameter int MSG_W   = 8,
    parameter bit ONE_PAR = 1'b0,
    parameter bit HAS_OV  = 1'b1,
    parameter int NH      = 4,
    parameter int PAR_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [MSG_W-1:0] msg,
    output logic [MSG_W-1:0] data_o,
    output logic [PAR_W-1:0] par_o
);

    typedef struct packed {
        logic [MSG_W-1:0] data;
        logic [PAR_W-1:0] par;
    } enc_st_t;

    enc_st_t st_d, st_q;
    logic [NH-1:0]    pos_tab [MSG_W];
    logic [NH-1:0]    ham;
    logic [PAR_W-1:0] par_calc;

    for (genvar k = 0; k < MSG_W; k++) begin : g_pos
        localparam int P = hc_data_pos(k);
        assign pos_tab[k] = ONE_PAR ? '0 : NH'(P);
    end

    always_comb begin
        ham = '0;
        for (int k = 0; k < MSG_W; k++) begin
            if (msg[k]) ham = ham ^ pos_tab[k];
        end
    end

    if (ONE_PAR) begin : g_single
        assign par_calc = ^msg;
    end else if (HAS_OV) begin : g_ov
        assign par_calc = {(^msg) ^ (^ham), ham};
    end else begin : g_plain
        assign par_calc = ham;
    end

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.data = msg;
            st_d.par  = par_calc;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign par_o  = st_q.par;

    p_enc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(data_o) && $stable(par_o)));

endmodule

// File: rtl/hc_dec.sv
`timescale 1ns/1ps
module hc_dec
    import hc_pkg::*;
#(
    parameter int MSG_W   = 8,
    parameter bit ONE_PAR = 1'b0,
    parameter bit HAS_OV  = 1'b1,
    parameter bit CORR_EN = 1'b1,
    parameter int NH      = 4,
    parameter int PAR_W   = 5,
    parameter int N       = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [MSG_W-1:0] data_i,
    input  logic [PAR_W-1:0] par_i,
    output logic [MSG_W-1:0] data_o,
    output logic             fix_o,
    output logic             det_o
);

    typedef struct packed {
        logic [MSG_W-1:0] data;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [NH-1:0]    pos_tab [MSG_W];
    logic [NH-1:0]    ham;
    logic [NH-1:0]    syn;
    logic             ov_fail;
    logic             err;
    logic             single;
    logic             fix;
    logic [MSG_W-1:0] repaired;

    for (genvar k = 0; k < MSG_W; k++) begin : g_pos
        localparam int P = hc_data_pos(k);
        assign pos_tab[k] = ONE_PAR ? '0 : NH'(P);
    end

    always_comb begin
        ham = '0;
        if (ONE_PAR) begin
            ham[0] = ^data_i;
        end else begin
            for (int k = 0; k < MSG_W; k++) begin
                if (data_i[k]) ham = ham ^ pos_tab[k];
            end
        end
        syn     = par_i[NH-1:0] ^ ham;
        ov_fail = HAS_OV ? ((^data_i) ^ (^par_i)) : 1'b0;
        err     = (syn != '0) || ov_fail;
        if (ONE_PAR)     single = 1'b0;
        else if (HAS_OV) single = ov_fail;
        else             single = err;
        // A syndrome beyond the codeword length cannot be a single error.
        fix      = CORR_EN && single && (int'(syn) <= N);
        repaired = data_i;
        if (fix) begin
            for (int k = 0; k < MSG_W; k++) begin
                if (pos_tab[k] == syn) repaired[k] = ~data_i[k];
            end
        end
    end

    assign fix_o = fix;
    assign det_o = err && !fix;

    always_comb begin
        st_d = st_q;
        if (en) st_d.data = repaired;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_o = st_q.data;

    p_dec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(data_o));

    p_clean_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (en && !fix_o && !det_o) |=> (data_o == $past(data_i)));

endmodule

// File: rtl/hc_sat_cnt.sv
`timescale 1ns/1ps
module hc_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (en && hit && st_q.cnt != CNT_MAX)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_o == '0));

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_MAX && !clr) |=> (cnt_o == CNT_MAX));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_o));

endmodule

// File: rtl/hc_codec_top.sv
`timescale 1ns/1ps
module hc_codec_top
    import hc_pkg::*;
#(
    parameter int MSG_W   = 8,
    parameter int CNT_W   = 16,
    parameter bit USE_OV  = 1'b1,
    parameter bit CORR_EN = 1'b1,
    parameter bit ONE_PAR = 1'b0,
    localparam int NH     = ONE_PAR ? 1 : hc_ham_bits(MSG_W),
    localparam bit HAS_OV = USE_OV && !ONE_PAR,
    localparam int PAR_W  = NH + (HAS_OV ? 1 : 0),
    localparam int N      = MSG_W + NH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_en,
    input  logic [MSG_W-1:0] enc_msg,
    output logic [MSG_W-1:0] enc_data,
    output logic [PAR_W-1:0] enc_par,
    input  logic             dec_en,
    input  logic [MSG_W-1:0] dec_data,
    input  logic [PAR_W-1:0] dec_par,
    input  logic             cnt_clr,
    output logic [MSG_W-1:0] dec_out,
    output logic [CNT_W-1:0] fix_cnt,
    output logic [CNT_W-1:0] det_cnt
);

    logic fix_hit;
    logic det_hit;

    hc_enc #(
        .MSG_W(MSG_W), .ONE_PAR(ONE_PAR), .HAS_OV(HAS_OV),
        .NH(NH), .PAR_W(PAR_W)
    ) i_enc (
        .clk(clk), .rst(rst), .en(enc_en), .msg(enc_msg),
        .data_o(enc_data), .par_o(enc_par)
    );

    hc_dec #(
        .MSG_W(MSG_W), .ONE_PAR(ONE_PAR), .HAS_OV(HAS_OV), .CORR_EN(CORR_EN),
        .NH(NH), .PAR_W(PAR_W), .N(N)
    ) i_dec (
        .clk(clk), .rst(rst), .en(dec_en), .data_i(dec_data), .par_i(dec_par),
        .data_o(dec_out), .fix_o(fix_hit), .det_o(det_hit)
    );

    hc_sat_cnt #(.CNT_W(CNT_W)) i_fix_cnt (
        .clk(clk), .rst(rst), .en(dec_en), .clr(cnt_clr), .hit(fix_hit),
        .cnt_o(fix_cnt)
    );

    hc_sat_cnt #(.CNT_W(CNT_W)) i_det_cnt (
        .clk(clk), .rst(rst), .en(dec_en), .clr(cnt_clr), .hit(det_hit),
        .cnt_o(det_cnt)
    );

    if (ONE_PAR || !CORR_EN) begin : g_no_fix
        p_no_fix_r5: assert property (@(posedge clk) disable iff (rst)
            fix_cnt == '0);
    end

endmodule

// File: tb/test_hc_codec_top.sv
`timescale 1ns/1ps
module test_hc_codec_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       enc_en = 1'b1;
    logic       dec_en = 1'b1;
    logic       cnt_clr = 1'b0;
    logic [7:0] msg = '0;
    logic [7:0] mask = '0;
    logic [7:0] mask_q;

    logic [7:0] ed_a, ed_b, ed_c, do_a, do_b, do_c;
    logic [4:0] ep_a, ep_c;
    logic [0:0] ep_b;
    logic [2:0] fx_a, fx_b, fx_c, dt_a, dt_b, dt_c;

    always @(posedge clk or posedge rst)
        if (rst) mask_q <= '0;
        else     mask_q <= mask;

    // A: overall parity + correction
    hc_codec_top #(.MSG_W(8), .CNT_W(3), .USE_OV(1'b1), .CORR_EN(1'b1), .ONE_PAR(1'b0)) i_hc_codec_top (
        .clk(clk), .rst(rst), .enc_en(enc_en), .enc_msg(msg), .enc_data(ed_a), .enc_par(ep_a),
        .dec_en(dec_en), .dec_data(ed_a ^ mask_q), .dec_par(ep_a), .cnt_clr(cnt_clr),
        .dec_out(do_a), .fix_cnt(fx_a), .det_cnt(dt_a));
    // B: single parity bit
    hc_codec_top #(.MSG_W(8), .CNT_W(3), .USE_OV(1'b0), .CORR_EN(1'b1), .ONE_PAR(1'b1)) i_hc_codec_top_b (
        .clk(clk), .rst(rst), .enc_en(enc_en), .enc_msg(msg), .enc_data(ed_b), .enc_par(ep_b),
        .dec_en(dec_en), .dec_data(ed_b ^ mask_q), .dec_par(ep_b), .cnt_clr(cnt_clr),
        .dec_out(do_b), .fix_cnt(fx_b), .det_cnt(dt_b));
    // C: overall parity, correction off
    hc_codec_top #(.MSG_W(8), .CNT_W(3), .USE_OV(1'b1), .CORR_EN(1'b0), .ONE_PAR(1'b0)) i_hc_codec_top_c (
        .clk(clk), .rst(rst), .enc_en(enc_en), .enc_msg(msg), .enc_data(ed_c), .enc_par(ep_c),
        .dec_en(dec_en), .dec_data(ed_c ^ mask_q), .dec_par(ep_c), .cnt_clr(cnt_clr),
        .dec_out(do_c), .fix_cnt(fx_c), .det_cnt(dt_c));

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         tgt;
        logic [7:0] da, db, dc;
        int         afx, adt, bfx, bdt, cfx, cdt;
        string      req;
    } item_t;
    item_t sb[$];

    int m_afx = 0, m_adt = 0, m_bdt = 0, m_cdt = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int sat7(input int v);
        return (v >= 7) ? 7 : v + 1;
    endfunction

    // Driver: applies one word with a fault mask and predicts all three variants.
    task automatic send(input logic [7:0] m, input logic [7:0] f, input string req);
        item_t it;
        int n;
        n = $countones(f);
        msg  = m;
        mask = f;
        it.tgt = cyc + 2;
        it.req = req;
        it.da = (n == 2) ? (m ^ f) : m;
        it.db = m ^ f;
        it.dc = m ^ f;
        if (n == 1) m_afx = sat7(m_afx);
        if (n == 2) m_adt = sat7(m_adt);
        if (n % 2 == 1) m_bdt = sat7(m_bdt);
        if (n > 0) m_cdt = sat7(m_cdt);
        it.afx = m_afx; it.adt = m_adt;
        it.bfx = 0;     it.bdt = m_bdt;
        it.cfx = 0;     it.cdt = m_cdt;
        sb.push_back(it);
        @(negedge clk);
        mask = '0;
    endtask

    task automatic flush();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops predictions as their cycle arrives.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].tgt == cyc) begin
            item_t it;
            it = sb.pop_front();
            chk(do_a == it.da, {it.req, " A data"}, do_a, it.da);
            chk(fx_a == it.afx[2:0], {it.req, " A fix_cnt"}, fx_a, it.afx);
            chk(dt_a == it.adt[2:0], {it.req, " A det_cnt"}, dt_a, it.adt);
            chk(do_b == it.db, "R6 B data", do_b, it.db);
            chk(fx_b == it.bfx[2:0], "R6 B fix_cnt", fx_b, it.bfx);
            chk(dt_b == it.bdt[2:0], "R6 B det_cnt", dt_b, it.bdt);
            chk(do_c == it.dc, "R5 C data", do_c, it.dc);
            chk(fx_c == it.cfx[2:0], "R5 C fix_cnt", fx_c, it.cfx);
            chk(dt_c == it.cdt[2:0], "R5 C det_cnt", dt_c, it.cdt);
        end
    end

    task automatic counters_zero(input string req);
        chk(fx_a == 0, req, fx_a, 0);
        chk(dt_a == 0, req, dt_a, 0);
        chk(dt_b == 0, req, dt_b, 0);
        chk(dt_c == 0, req, dt_c, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        logic [7:0] h_do, h_ed;
        logic [4:0] h_ep;
        logic [2:0] h_fx, h_dt;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(do_a == 0 && do_b == 0 && do_c == 0, "R10 reset dec_out", do_a, 0);
        chk(ed_a == 0 && ep_a == 0, "R10 reset enc", {ed_a, 3'b0, ep_a}, 0);
        counters_zero("R10 reset counters");
        rst = 1'b0;
        @(negedge clk);

        // R2: code layout
        chk($bits(ep_a) == 5, "R2 par width A", $bits(ep_a), 5);
        chk($bits(ep_b) == 1, "R2 par width B", $bits(ep_b), 1);
        send(8'h01, 8'h00, "R1");
        chk(ep_a == 5'h13, "R2 par A msg 01", ep_a, 5'h13);
        chk(ep_b == 1'b1, "R2 par B msg 01", ep_b, 1);
        send(8'h80, 8'h00, "R1");
        chk(ep_a == 5'h1C, "R2 par A msg 80", ep_a, 5'h1C);
        send(8'hB4, 8'h00, "R1");
        chk(ep_b == 1'b0, "R2 par B msg B4", ep_b, 0);

        // R1: clean words of several patterns
        send(8'h00, 8'h00, "R1");
        send(8'hFF, 8'h00, "R1");
        send(8'hA5, 8'h00, "R1");
        send(8'h5A, 8'h00, "R1");
        for (int b = 0; b < 8; b++) send(8'(1 << b), 8'h00, "R1");
        lf = 8'h9D;
        for (int i = 0; i < 6; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            send(lf, 8'h00, "R1");
        end

        // R3: single faults, each on a different bit
        for (int b = 0; b < 5; b++) send(8'h3C ^ 8'(b * 37), 8'(1 << b), "R3");
        // R4: double faults
        send(8'hC3, 8'h81, "R4");
        send(8'h6E, 8'h18, "R4");
        flush();

        // R8: clear pulse
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        counters_zero("R8 after clear");
        m_afx = 0; m_adt = 0; m_bdt = 0; m_cdt = 0;
        @(negedge clk);
        counters_zero("R8 clear lasting");

        // R9: both enables low, faults applied, nothing moves
        h_do = do_a; h_ed = ed_a; h_ep = ep_a; h_fx = fx_a; h_dt = dt_c;
        enc_en = 1'b0; dec_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            msg = 8'h11 * 8'(i + 3);
            mask = 8'h04;
            @(negedge clk);
            chk(do_a == h_do, "R9 dec_out hold", do_a, h_do);
            chk(ed_a == h_ed && ep_a == h_ep, "R9 enc hold", {ed_a, 3'b0, ep_a}, {h_ed, 3'b0, h_ep});
            chk(fx_a == h_fx && dt_c == h_dt, "R9 counters hold", {fx_a, dt_c}, {h_fx, h_dt});
        end
        mask = 8'h00;
        @(negedge clk);
        enc_en = 1'b1; dec_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        counters_zero("R9 no count after re-enable");

        // R7: push past saturation
        for (int i = 0; i < 10; i++) send(8'h5B ^ 8'(i), 8'(1 << (i % 8)), "R7");
        flush();
        chk(fx_a == 3'd7, "R7 A fix saturated", fx_a, 7);
        chk(dt_b == 3'd7, "R7 B det saturated", dt_b, 7);
        chk(dt_c == 3'd7, "R7 C det saturated", dt_c, 7);

        // R8: clear coincides with a faulty word reaching the decoder
        msg = 8'h3C; mask = 8'h02;
        @(negedge clk);
        mask = 8'h00; cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        counters_zero("R8 clear beats increment");
        chk(do_a == 8'h3C, "R3 repaired during clear", do_a, 8'h3C);
        @(negedge clk);
        counters_zero("R8 zero after collision");
        m_afx = 0; m_adt = 0; m_bdt = 0; m_cdt = 0;

        // R10: asynchronous reset between edges
        send(8'h77, 8'h10, "R3");
        flush();
        chk(fx_a == 3'd1, "R3 single counted", fx_a, 1);
        #1 rst = 1'b1;
        #0.5;
        chk(do_a == 0 && ed_a == 0, "R10 async clear data", {do_a, ed_a}, 0);
        chk(fx_a == 0 && dt_b == 0 && dt_c == 0, "R10 async clear counters", {fx_a, dt_b, dt_c}, 0);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule